// File: doc/BRIEF.md
# Deep Stop Sequencer

This block moves a microcontroller between run mode and a deep stop mode in which only RAM keeps power. When the CPU signals a stop, the sequencer freezes the I/O pin control signals and gates the core clocks. It also places the voltage regulator in standby unless one of two conditions overrides it. The first override is the low-voltage detector being armed for stop. The second is the debug enable bit being set. The debug enable also keeps the debug clocks alive, so a debug host can still talk to the part while it sleeps.

All wake inputs pass through a two-flop synchronizer on one free-running low-power clock. A wake from deep stop raises a single-cycle power-on-style reset request. It also sets a sticky partial-power-down flag, and the pins stay frozen until software writes an acknowledge. A debug wake command takes a different path. It returns the part to run in a debug-halted state, with no reset and no flag.

Top module: `deepstop_ctrl`

## Requirements
- R1: One cycle after `stop_req` is sampled high in run (with no wake source active), `stop_active` and `pin_hold` are 1 and `core_clk_en` is 0; with no override, `reg_standby` is 1 and `dbg_clk_en` is 0.
- R2: If `lvd_en` and `lvd_stop_en` are both 1 when stop is entered, `reg_standby` stays 0 for the whole stop; either bit alone does not prevent standby.
- R3: If `dbg_en` is 1 when stop is entered, `dbg_clk_en` stays 1 and `reg_standby` stays 0 during stop.
- R4: Any `wake_pin` bit high, `irq_n` low or `ext_rst_n` low ends stop. The state leaves stop on the third clock edge after the input changes: two synchronizer edges, then the decision edge. `irq_n` is always treated as an active-low wake.
- R5: A high `rti_tick` wakes the part only while `rti_en` is 1; with `rti_en` at 0 the part stays in stop.
- R6: A wake from stop produces a `por_req` pulse exactly one cycle long, even if the wake source stays asserted; the part is in run on the following cycle.
- R7: `ppd_flag` is set on the same edge that raises `por_req`. `ppd_flag` and `pin_hold` stay 1 until a register write with `reg_wdata` bit 0 set.
- R8: A register write with `reg_wdata` bit 0 clear leaves `ppd_flag` unchanged. Writing 1 while the flag is already clear keeps it clear.
- R9: A stop request sampled while a synchronized wake source is active keeps the part in run: `stop_active` 0, `core_clk_en` 1, `pin_hold` unchanged, no `por_req`.
- R10: In a stop entered with `dbg_en` at 1, a `dbg_wake` pulse returns to run on the next edge. It gives a one-cycle `dbg_halt`, with no `por_req` and no change to `ppd_flag`. In a stop entered without `dbg_en`, `dbg_wake` is ignored.
- R11: `dbg_mem_err` is 1 only while `dbg_mem_req` is 1 during a stop entered with `dbg_en` at 1; it is 0 in run.
- R12: After reset, `stop_active`, `reg_standby`, `pin_hold`, `por_req`, `dbg_halt` and `ppd_flag` are 0, and `core_clk_en` and `dbg_clk_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-power clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stop_req | input | 1 | CPU stop request, sampled each cycle |
| lvd_en | input | 1 | Low-voltage detector enable |
| lvd_stop_en | input | 1 | Low-voltage detector kept on in stop |
| dbg_en | input | 1 | Debug mode enable |
| wake_pin | input | NWAKE | Active-high wake pins |
| irq_n | input | 1 | Interrupt pin, active-low wake in stop |
| ext_rst_n | input | 1 | External reset pin, active low |
| rti_en | input | 1 | Periodic wake enable |
| rti_tick | input | 1 | Periodic wake tick |
| dbg_wake | input | 1 | Debug wake command |
| dbg_mem_req | input | 1 | Debug memory access request with status |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | WDATA_W | Write data; bit 0 is the acknowledge |
| reg_standby | output | 1 | Regulator standby request |
| core_clk_en | output | 1 | Core clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| pin_hold | output | 1 | I/O pin control latch hold |
| por_req | output | 1 | Power-on-style reset request pulse |
| dbg_halt | output | 1 | Enter debug-halted run pulse |
| dbg_mem_err | output | 1 | Error status for debug memory access |
| stop_active | output | 1 | Deep stop in progress |
| ppd_flag | output | 1 | Sticky partial-power-down flag |

## Verification
The embedded assertions check several properties on every cycle. The reset request never lasts beyond one cycle, and it is always accompanied by a set flag. The flag only falls after an acknowledge write. Standby is only entered when neither override was present at entry. A stop request seen together with a wake keeps the part in run. The debug memory error only appears with the core clock gated. Only the bench's scenarios can show the rest: synchronizer latency for each wake source, the effect of the periodic-wake enable, the ignored acknowledge writes, and the debug wake path.

// File: rtl/dstop_pkg.sv
package dstop_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } dstop_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= RST_VAL;
        else        stg[k] <= stg[k-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import dstop_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_req,
  input  logic         keep_reg_in,
  input  logic         keep_dbg_in,
  input  logic         wake_any,
  input  logic         dbg_wake,
  output dstop_state_e state,
  output logic         keep_reg_q,
  output logic         keep_dbg_q,
  output logic         wake_hit,
  output logic         dbg_halt
);
  dstop_state_e state_q, state_d;
  logic         enter_stop;
  logic         halt_d, halt_q;

  always_comb begin
    state_d    = state_q;
    enter_stop = 1'b0;
    wake_hit   = 1'b0;
    halt_d     = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (stop_req && !wake_any) begin
          state_d    = ST_STOP;
          enter_stop = 1'b1;
        end
      end
      ST_STOP: begin
        if (wake_any) begin
          state_d  = ST_WAKE;
          wake_hit = 1'b1;
        end else if (dbg_wake && keep_dbg_q) begin
          state_d = ST_RUN;
          halt_d  = 1'b1;
        end
      end
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      keep_reg_q <= 1'b0;
      keep_dbg_q <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      if (enter_stop) begin
        keep_reg_q <= keep_reg_in;
        keep_dbg_q <= keep_dbg_in;
      end
    end
  end

  assign state    = state_q;
  assign dbg_halt = halt_q;

  // R9
  stop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && stop_req && wake_any) |=> (state_q == ST_RUN));

  // R6
  wake_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN));

  // R10
  halt_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (state_q == ST_RUN) && $past(state_q == ST_STOP));
endmodule

// File: rtl/ppd_flag_reg.sv
module ppd_flag_reg #(
  parameter int WDATA_W = 8,
  parameter int ACK_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_pulse,
  input  logic               reg_wr,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic               flag
);
  logic flag_q, flag_d, ack_wr;

  assign ack_wr = reg_wr && reg_wdata[ACK_BIT];

  always_comb begin
    flag_d = flag_q;
    if (set_pulse)   flag_d = 1'b1;
    else if (ack_wr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R8
  flag_clear_only_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ack_wr));

  // R7
  flag_rise_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_pulse));
endmodule

// File: rtl/deepstop_ctrl.sv
module deepstop_ctrl
  import dstop_pkg::*;
#(
  parameter int NWAKE       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WDATA_W     = 8,
  parameter int ACK_BIT     = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req,
  input  logic               lvd_en,
  input  logic               lvd_stop_en,
  input  logic               dbg_en,
  input  logic [NWAKE-1:0]   wake_pin,
  input  logic               irq_n,
  input  logic               ext_rst_n,
  input  logic               rti_en,
  input  logic               rti_tick,
  input  logic               dbg_wake,
  input  logic               dbg_mem_req,
  input  logic               reg_wr,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic               reg_standby,
  output logic               core_clk_en,
  output logic               dbg_clk_en,
  output logic               pin_hold,
  output logic               por_req,
  output logic               dbg_halt,
  output logic               dbg_mem_err,
  output logic               stop_active,
  output logic               ppd_flag
);
  localparam int           SW      = NWAKE + 3;
  localparam logic [SW-1:0] SRST   = {1'b0, 1'b1, 1'b1, {NWAKE{1'b0}}};

  logic [SW-1:0]    sync_in, sync_out;
  logic [NWAKE-1:0] s_pin;
  logic             s_irq_n, s_ext_rst_n, s_rti;
  logic             wake_any, wake_hit, keep_reg_q, keep_dbg_q, keep_reg_in;
  dstop_state_e     state;

  assign sync_in = {rti_tick, ext_rst_n, irq_n, wake_pin};

  lp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SRST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sync_in),
    .dout (sync_out)
  );

  assign s_pin       = sync_out[NWAKE-1:0];
  assign s_irq_n     = sync_out[NWAKE];
  assign s_ext_rst_n = sync_out[NWAKE+1];
  assign s_rti       = sync_out[NWAKE+2];

  assign wake_any    = (|s_pin) || !s_irq_n || !s_ext_rst_n || (rti_en && s_rti);
  assign keep_reg_in = (lvd_en && lvd_stop_en) || dbg_en;

  stop_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .keep_reg_in(keep_reg_in),
    .keep_dbg_in(dbg_en),
    .wake_any   (wake_any),
    .dbg_wake   (dbg_wake),
    .state      (state),
    .keep_reg_q (keep_reg_q),
    .keep_dbg_q (keep_dbg_q),
    .wake_hit   (wake_hit),
    .dbg_halt   (dbg_halt)
  );

  ppd_flag_reg #(.WDATA_W(WDATA_W), .ACK_BIT(ACK_BIT)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse(wake_hit),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .flag     (ppd_flag)
  );

  assign stop_active = (state == ST_STOP);
  assign por_req     = (state == ST_WAKE);
  assign core_clk_en = !stop_active;
  assign dbg_clk_en  = !stop_active || keep_dbg_q;
  assign reg_standby = stop_active && !keep_reg_q;
  assign pin_hold    = stop_active || ppd_flag;
  assign dbg_mem_err = stop_active && keep_dbg_q && dbg_mem_req;

  // R6
  por_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> !por_req);

  // R7
  por_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |-> ppd_flag && pin_hold);

  // R2
  standby_no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_standby) |-> $past(!(lvd_en && lvd_stop_en) && !dbg_en));

  // R11
  mem_err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mem_err |-> !core_clk_en && dbg_clk_en);
endmodule

// File: tb/sim_deepstop_ctrl.sv
module sim_deepstop_ctrl;
  logic       clk, rst_n, stop_req, lvd_en, lvd_stop_en, dbg_en;
  logic [3:0] wake_pin;
  logic       irq_n, ext_rst_n, rti_en, rti_tick, dbg_wake, dbg_mem_req, reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_standby, core_clk_en, dbg_clk_en, pin_hold, por_req;
  logic       dbg_halt, dbg_mem_err, stop_active, ppd_flag;
  int         total, bad;
  bit         done;

  deepstop_ctrl u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {lvd_en, lvd_stop_en, dbg_en, exp reg_standby, exp dbg_clk_en}
  localparam logic [4:0] VEC [8] = '{
    5'b00010, 5'b00101, 5'b01010, 5'b01101,
    5'b10010, 5'b10101, 5'b11000, 5'b11101
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop();
    stop_req = 1'b1; step(1); stop_req = 1'b0;
  endtask

  task automatic idle_all();
    wake_pin = '0; irq_n = 1'b1; ext_rst_n = 1'b1; rti_tick = 1'b0; rti_en = 1'b0;
    dbg_wake = 1'b0; dbg_mem_req = 1'b0; stop_req = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ack(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(1); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    idle_all(); lvd_en = 0; lvd_stop_en = 0; dbg_en = 0;
    rst_n = 1'b0;
    step(3);
    // R12 reset state
    check("R12 stop_active", stop_active, 0);
    check("R12 reg_standby", reg_standby, 0);
    check("R12 core_clk_en", core_clk_en, 1);
    check("R12 dbg_clk_en", dbg_clk_en, 1);
    check("R12 pin_hold", pin_hold, 0);
    check("R12 por_req", por_req, 0);
    check("R12 ppd_flag", ppd_flag, 0);
    check("R12 dbg_halt", dbg_halt, 0);
    rst_n = 1'b1;
    step(2);

    // Vector walk: R1 R2 R3 entry, R4 pin wake, R6 pulse, R7 flag
    for (int i = 0; i < 8; i++) begin
      lvd_en = VEC[i][4]; lvd_stop_en = VEC[i][3]; dbg_en = VEC[i][2];
      enter_stop();
      check("R1 stop_active", stop_active, 1);
      check("R1 core_clk_en", core_clk_en, 0);
      check("R1 pin_hold", pin_hold, 1);
      check("R2 reg_standby", reg_standby, VEC[i][1]);
      check("R3 dbg_clk_en", dbg_clk_en, VEC[i][0]);
      wake_pin[i % 4] = 1'b1;
      step(2);
      check("R4 still stopped", stop_active, 1);
      step(1);
      check("R6 por_req", por_req, 1);
      check("R7 ppd_flag", ppd_flag, 1);
      step(1);
      check("R6 por_req drop", por_req, 0);
      check("R6 run", stop_active, 0);
      check("R7 pin_hold", pin_hold, 1);
      wake_pin = '0;
      step(3);
      check("R7 flag sticky", ppd_flag, 1);
      ack(8'h01);
      check("R7 flag cleared", ppd_flag, 0);
      check("R7 pins released", pin_hold, 0);
    end
    lvd_en = 0; lvd_stop_en = 0; dbg_en = 0;

    // R4 irq_n wake
    enter_stop();
    irq_n = 1'b0; step(3);
    check("R4 irq wake", por_req, 1);
    irq_n = 1'b1; step(4); ack(8'h01);
    // R4 external reset wake
    enter_stop();
    ext_rst_n = 1'b0; step(3);
    check("R4 ext reset wake", por_req, 1);
    ext_rst_n = 1'b1; step(4);

    // R8 ignored acknowledge writes
    ack(8'h00);
    check("R8 write zero", ppd_flag, 1);
    ack(8'h02);
    check("R8 other bit", ppd_flag, 1);
    ack(8'h01);
    check("R8 ack clears", ppd_flag, 0);
    ack(8'h01);
    check("R8 ack when clear", ppd_flag, 0);
    check("R8 pins free", pin_hold, 0);

    // R5 periodic wake gating
    enter_stop();
    rti_tick = 1'b1; step(5);
    check("R5 tick disabled", stop_active, 1);
    check("R5 no por", por_req, 0);
    rti_en = 1'b1; step(1);
    check("R5 tick enabled", por_req, 1);
    // R6 source held: single pulse
    step(1);
    check("R6 held source", por_req, 0);
    step(2);
    check("R6 still no pulse", por_req, 0);
    // R9 stop while wake active
    enter_stop();
    check("R9 stays run", stop_active, 0);
    check("R9 clock on", core_clk_en, 1);
    check("R9 no por", por_req, 0);
    rti_tick = 1'b0; rti_en = 1'b0; step(3); ack(8'h01);
    check("R9 flag clear", ppd_flag, 0);
    wake_pin[2] = 1'b1; step(3);
    enter_stop();
    check("R9 pins not held", pin_hold, 0);
    check("R9 run kept", stop_active, 0);
    wake_pin = '0; step(3);

    // R10 / R11 debug path
    check("R11 err in run", dbg_mem_err, 0);
    dbg_en = 1'b1;
    enter_stop();
    dbg_mem_req = 1'b1; step(1);
    check("R11 err in stop", dbg_mem_err, 1);
    dbg_mem_req = 1'b0;
    dbg_wake = 1'b1; step(1); dbg_wake = 1'b0;
    check("R10 run", stop_active, 0);
    check("R10 halt", dbg_halt, 1);
    check("R10 no por", por_req, 0);
    check("R10 no flag", ppd_flag, 0);
    step(1);
    check("R10 halt pulse", dbg_halt, 0);
    dbg_en = 1'b0;
    enter_stop();
    dbg_mem_req = 1'b1; step(1);
    check("R11 no debug", dbg_mem_err, 0);
    dbg_mem_req = 1'b0;
    dbg_wake = 1'b1; step(1); dbg_wake = 1'b0;
    check("R10 wake ignored", stop_active, 1);
    check("R10 no halt", dbg_halt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule